// File: doc/BRIEF.md
# Select-Gated General-Purpose Port with PWM Steering

This block is a register-mapped general-purpose port with eight input pins and eight output pins. A ten-bit select register decides, bit by bit, whether each output is driven from a software-written output register or passes through an alternate-function signal supplied by a neighbouring peripheral. Two further select bits steer an externally generated PWM waveform onto output pin 7 and, through an enable flag, onto the shared bidirectional pin 7.

Software reaches the block through a single-cycle register port. It has a two-bit word index, a write strobe, write data and combinational read data. Writes to the output register are masked by the select bits, so only pins under software control change. Reads of the output register return what is actually on the pins, whether that value comes from the register, an alternate function or the PWM source. The input pins pass through a two-flop synchroniser before software can read them.

Top module: `gpio_sel_port`

## Requirements
- R1: After a synchronous reset, the select register and the output register are zero, every output pin shows its alternate-function input, and `io7_pwm_en` is low.
- R2: A write to word index 0 (output register) loads write-data bit n into output-register bit n only where select bit n is 1. Bits whose select bit is 0 keep their stored value.
- R3: For each pin n whose select bit n (bits 0 to 7) is 0, `gpio_out[n]` equals `alt_in[n]`. This holds unless n is 7 and select bit 8 is set.
- R4: A read of word index 0 returns the present value of `gpio_out` in bits 7:0, with zeros above.
- R5: A read of word index 1 returns `gpio_in` as it was two clock edges earlier, in bits 7:0, with zeros above.
- R6: Word index 3 is the select register. A write stores write-data bits 9:0. A read returns them in bits 9:0 with zeros above.
- R7: When select bit 8 is 1, `gpio_out[7]` follows `pwm_in`, whatever select bit 7 and output-register bit 7 hold.
- R8: `io7_pwm_en` equals select bit 9.
- R9: Word index 2 reads as zero. A write to it changes neither the select register nor the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word index: 0 output, 1 input, 2 unused, 3 select |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| gpio_in | input | 8 | Asynchronous input pins |
| alt_in | input | 8 | Alternate-function value for each output pin |
| pwm_in | input | 1 | PWM waveform from an external generator |
| gpio_out | output | 8 | Output pins |
| io7_pwm_en | output | 1 | Requests PWM on bidirectional pin 7 |

## Verification
The hardest case to reach from the ports is a masked write that leaves hidden state untouched. When software writes the output register while a pin is unselected, the new value is invisible, because that pin shows its alternate function. The stimulus therefore writes all ones with the select register cleared. It then enables a subset of select bits and reads the pins back, which exposes the stored zeros. The same approach covers the PWM override on pin 7. Output bit 7 is set underneath the override and only becomes visible once select bit 8 is dropped. A randomised phase then mixes writes to all four indices with changing pins, checked each cycle against a behavioural model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int N_PINS  = 8;
    localparam int SEL_W   = N_PINS + 2;
    localparam int RDATA_W = 32;
    localparam int ADDR_W  = 2;
    localparam int PWM_PIN = N_PINS - 1;

    typedef enum logic [ADDR_W-1:0] {
        IDX_OUT = 2'd0,
        IDX_IN  = 2'd1,
        IDX_RSV = 2'd2,
        IDX_SEL = 2'd3
    } reg_idx_e;

    // Packed so that bit 9 is io_pwm, bit 8 pin_pwm and bits 7:0 gp_en
    typedef struct packed {
        logic              io_pwm;
        logic              pin_pwm;
        logic [N_PINS-1:0] gp_en;
    } sel_t;

    function automatic logic [N_PINS-1:0] masked_merge(
        input logic [N_PINS-1:0] old_v,
        input logic [N_PINS-1:0] new_v,
        input logic [N_PINS-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic [RDATA_W-1:0] zext_pins(input logic [N_PINS-1:0] v);
        return {{(RDATA_W-N_PINS){1'b0}}, v};
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pins_async,
    output logic [N_PINS-1:0] pins_sync
);
    logic [N_PINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= pins_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pins_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_out,
    input  logic              wr_sel,
    input  logic [SEL_W-1:0]  wdata,
    input  logic [N_PINS-1:0] alt_in,
    input  logic              pwm_in,
    output sel_t              sel_q,
    output logic [N_PINS-1:0] pins,
    output logic              io_pwm_en
);
    logic [N_PINS-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            out_q <= '0;
        end else begin
            if (wr_sel) sel_q <= sel_t'(wdata);
            if (wr_out) out_q <= masked_merge(out_q, wdata[N_PINS-1:0], sel_q.gp_en);
        end
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic gp_val;
        assign gp_val = sel_q.gp_en[i] ? out_q[i] : alt_in[i];
        if (i == PWM_PIN) begin : g_pwm
            // PWM steering wins over software drive on this pin
            assign pins[i] = sel_q.pin_pwm ? pwm_in : gp_val;
        end else begin : g_plain
            assign pins[i] = gp_val;
        end
    end

    assign io_pwm_en = sel_q.io_pwm;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_pkg::*;
(
    input  reg_idx_e           idx,
    input  logic [N_PINS-1:0]  pins,
    input  logic [N_PINS-1:0]  in_sync,
    input  sel_t               sel_q,
    output logic [RDATA_W-1:0] rdata
);
    always_comb begin
        unique case (idx)
            IDX_OUT: rdata = zext_pins(pins);
            IDX_IN:  rdata = zext_pins(in_sync);
            IDX_SEL: rdata = {{(RDATA_W-SEL_W){1'b0}}, sel_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_sel_port.sv
module gpio_sel_port
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [SEL_W-1:0]   bus_wdata,
    output logic [RDATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0]  gpio_in,
    input  logic [N_PINS-1:0]  alt_in,
    input  logic               pwm_in,
    output logic [N_PINS-1:0]  gpio_out,
    output logic               io7_pwm_en
);
    reg_idx_e          idx;
    logic              wr_out, wr_sel;
    sel_t              sel_q;
    logic [SEL_W-1:0]  sel_bits;
    logic [N_PINS-1:0] in_sync;

    assign idx    = reg_idx_e'(bus_addr);
    assign wr_out = bus_wr && (idx == IDX_OUT);
    assign wr_sel = bus_wr && (idx == IDX_SEL);

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pins_async(gpio_in),
        .pins_sync (in_sync)
    );

    gpio_out_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_out   (wr_out),
        .wr_sel   (wr_sel),
        .wdata    (bus_wdata),
        .alt_in   (alt_in),
        .pwm_in   (pwm_in),
        .sel_q    (sel_q),
        .pins     (gpio_out),
        .io_pwm_en(io7_pwm_en)
    );

    gpio_rd_mux u_rd (
        .idx    (idx),
        .pins   (gpio_out),
        .in_sync(in_sync),
        .sel_q  (sel_q),
        .rdata  (bus_rdata)
    );

    assign sel_bits = sel_q;
endmodule

// File: rtl/gpio_sel_port_chk.sv
module gpio_sel_port_chk
    import gpio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [SEL_W-1:0]   bus_wdata,
    input logic [RDATA_W-1:0] bus_rdata,
    input logic [N_PINS-1:0]  gpio_in,
    input logic [N_PINS-1:0]  alt_in,
    input logic               pwm_in,
    input logic [N_PINS-1:0]  gpio_out,
    input logic               io7_pwm_en,
    input logic [SEL_W-1:0]   sel_q
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (sel_q == '0) && !io7_pwm_en);

    for (genvar i = 0; i < N_PINS; i++) begin : g_bit
        // R2
        masked_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == 2'd0 && sel_q[i] && !(i == PWM_PIN && sel_q[8]))
            |=> gpio_out[i] == $past(bus_wdata[i]));
        // R3
        alt_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (!sel_q[i] && !(i == PWM_PIN && sel_q[8])) |-> gpio_out[i] == alt_in[i]);
    end

    // R4
    out_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> bus_rdata == zext_pins(gpio_out));

    // R5
    in_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1 && since_rst >= 2'd2) |-> bus_rdata == zext_pins($past(gpio_in, 2)));

    // R6
    sel_store_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=> sel_q == $past(bus_wdata));

    // R7
    pwm_pin_chk: assert property (@(posedge clk) disable iff (rst)
        sel_q[8] |-> gpio_out[PWM_PIN] == pwm_in);

    // R8
    io_pwm_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=> io7_pwm_en == $past(bus_wdata[9]));

    // R9
    rsv_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd2) |-> bus_rdata == '0);

    // R9
    rsv_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2) |=> $stable(sel_q));
endmodule

bind gpio_sel_port gpio_sel_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_in   (gpio_in),
    .alt_in    (alt_in),
    .pwm_in    (pwm_in),
    .gpio_out  (gpio_out),
    .io7_pwm_en(io7_pwm_en),
    .sel_q     (sel_bits)
);

// File: tb/sim_gpio_sel_port.sv
`timescale 1ns/100ps
module sim_gpio_sel_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [9:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  gpio_in = '0;
    logic [7:0]  alt_in = 8'hA5;
    logic        pwm_in = 1'b0;
    logic [7:0]  gpio_out;
    logic        io7_pwm_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    gpio_sel_port u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
        .alt_in(alt_in), .pwm_in(pwm_in), .gpio_out(gpio_out),
        .io7_pwm_en(io7_pwm_en)
    );

    // behavioural reference model
    logic [9:0] m_sel;
    logic [7:0] m_out, m_s1, m_s2;

    always @(posedge clk) begin
        if (rst) begin
            m_sel <= '0; m_out <= '0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            m_s1 <= gpio_in;
            m_s2 <= m_s1;
            if (bus_wr && bus_addr == 2'd3) m_sel <= bus_wdata;
            if (bus_wr && bus_addr == 2'd0)
                for (int b = 0; b < 8; b++)
                    if (m_sel[b]) m_out[b] <= bus_wdata[b];
        end
    end

    function automatic logic [7:0] exp_pins();
        logic [7:0] p;
        for (int b = 0; b < 8; b++) p[b] = m_sel[b] ? m_out[b] : alt_in[b];
        if (m_sel[8]) p[7] = pwm_in;
        return p;
    endfunction

    function automatic logic [31:0] exp_rd();
        case (bus_addr)
            2'd0:    return {24'd0, exp_pins()};
            2'd1:    return {24'd0, m_s2};
            2'd3:    return {22'd0, m_sel};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R3 pins vs model", {24'd0, gpio_out}, {24'd0, exp_pins()});
            chk("R8 io7 vs model", {31'd0, io7_pwm_en}, {31'd0, m_sel[9]});
            chk("R4 rdata vs model", bus_rdata, exp_rd());
        end
    end

    task automatic wr(input logic [1:0] a, input logic [9:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cmp_on = 1;
        @(negedge clk);
        chk("R1 pins show alt", {24'd0, gpio_out}, 32'h0000_00A5);
        chk("R1 io7 low", {31'd0, io7_pwm_en}, 32'd0);
        rd(2'd3, d); chk("R1 sel zero", d, 32'd0);

        // masked write with nothing selected, then expose stored bits
        wr(2'd0, 10'h0FF);
        wr(2'd3, 10'h00F);
        rd(2'd0, d); chk("R2 unselected write ignored", d, 32'h0000_00A0);
        wr(2'd0, 10'h0FF);
        rd(2'd0, d); chk("R2 selected bits loaded", d, 32'h0000_00AF);
        @(posedge clk); #1 alt_in = 8'h3C;
        @(negedge clk); chk("R3 alt follows", bus_rdata, 32'h0000_003F);
        chk("R4 read shows pins", {24'd0, gpio_out}, bus_rdata);

        // select register readback, upper bits zero
        wr(2'd3, 10'h3FF);
        rd(2'd3, d); chk("R6 sel readback", d, 32'h0000_03FF);
        chk("R8 io7 set", {31'd0, io7_pwm_en}, 32'd1);
        wr(2'd0, 10'h080);
        @(posedge clk); #1 bus_wr = 1'b0; pwm_in = 1'b0;
        @(negedge clk); chk("R7 pwm low overrides", {31'd0, gpio_out[7]}, 32'd0);
        @(posedge clk); #1 pwm_in = 1'b1;
        @(negedge clk); chk("R7 pwm high", {31'd0, gpio_out[7]}, 32'd1);
        @(posedge clk); #1 pwm_in = 1'b0;
        wr(2'd3, 10'h080);
        rd(2'd0, d); chk("R7 stored bit7 after override off", d[7], 1'b1);
        chk("R8 io7 cleared", {31'd0, io7_pwm_en}, 32'd0);
        wr(2'd3, 10'h200);
        rd(2'd0, d); chk("R8 io7 only, out7 is alt", d, 32'h0000_003C);
        chk("R8 io7 only set", {31'd0, io7_pwm_en}, 32'd1);

        // unused index
        wr(2'd2, 10'h3FF);
        rd(2'd2, d); chk("R9 reserved reads zero", d, 32'd0);
        rd(2'd3, d); chk("R9 reserved write no effect", d, 32'h0000_0200);

        // input synchroniser latency
        @(posedge clk); #1 bus_wr = 1'b0; bus_addr = 2'd1; gpio_in = 8'h00;
        repeat (3) @(posedge clk);
        #1 gpio_in = 8'h5A;
        @(negedge clk); chk("R5 not yet 0", bus_rdata, 32'd0);
        @(negedge clk); chk("R5 not yet 1", bus_rdata, 32'd0);
        @(negedge clk); chk("R5 after two edges", bus_rdata, 32'h0000_005A);

        // randomised mix, checked against the model every cycle
        for (int k = 0; k < 600; k++) begin
            @(posedge clk); #1;
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wdata = 10'($urandom());
            gpio_in   = 8'($urandom());
            alt_in    = 8'($urandom());
            pwm_in    = 1'($urandom());
        end
        @(posedge clk); #1 bus_wr = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule